// File: doc/BRIEF.md
# Keyed Configuration Data Port

This block gives boot firmware a narrow window onto a table of configuration items. Firmware first writes a 16-bit key to the selector. It then pulls the chosen item out one byte at a time through a single data port, and the position inside the item advances on its own after every byte. Reading beyond the end of an item, or reading through a key that names no entry, returns zero and leaves the position where it is. The same rule covers an entry whose length is zero. The data port is how firmware detects the device: it reads the signature item at key 0, which is the item selected out of reset.

Items are kept in two banks of byte storage, a generic bank and an architecture-local bank, and one key bit chooses between them. A second key bit marks the selection as a write channel. Through such a key, firmware writes data-port bytes into the entry. When the last byte of the entry's length lands, the block raises a one-cycle completion pulse that carries the bank and the entry index, and the position wraps to zero. A host-side load port fills entry bytes and sets entry lengths. It is used only while the data port is idle. Multi-byte numeric items are loaded least significant byte first, so firmware reads them little-endian.

Top module: `cfg_keyport`

## Requirements
- R1: A cycle with `selWr` high loads `selKey` as the current key and sets the byte position to zero. If `dataRd` is high in that same cycle, the read returns 0x00, the position stays at zero, and a same-cycle `dataWr` is ignored.
- R2: A key whose bits 13:0 hold a value of ENTRIES or more makes the selection invalid. While the selection is invalid, data reads return 0x00 without advancing the position, and data writes store nothing and raise no completion.
- R3: A data read through a valid key with position below the entry length puts the byte at that position on `dataRdByte` after the next rising edge, and advances the position by one. At or past the entry length, which includes a length of 0, the read gives 0x00 and the position does not move.
- R4: Key bit 15 set selects the architecture-local bank (bank 1), and bit 15 clear selects the generic bank (bank 0). The same index in the two banks names two independent entries.
- R5: A data write is stored only when key bit 14 is set and the position is below the entry length. The byte goes to the current position, the position advances by one, and the byte can be read back through the same entry afterwards. A write through a key with bit 14 clear changes nothing.
- R6: A write that brings the position to the entry length raises `doneValid` for exactly the cycle after that edge. During that cycle `doneBank` and `doneIndex` hold the entry's bank and index, and the position returns to zero.
- R7: After reset the current key is 0, the position is 0, all entry lengths are 0, `dataRdByte` is 0x00 and `doneValid` is low. Data reads issued straight after reset come from bank 0, entry 0.
- R8: `ldByteWr` writes `ldByte` to bank `ldBank`, entry `ldIndex`, position `ldOffset`. `ldLenWr` sets that entry's length to `ldLen`, saturated at MAX_BYTES.
- R9: When `dataRd` and `dataWr` are both high without `selWr`, only the read takes effect: the position advances by one at most, nothing is stored and there is no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| selWr | input | 1 | Selector write strobe |
| selKey | input | 16 | Key: bit 15 bank, bit 14 write channel, bits 13:0 index |
| dataRd | input | 1 | Data-port byte read strobe |
| dataRdByte | output | 8 | Byte returned by the most recent data read |
| dataWr | input | 1 | Data-port byte write strobe |
| dataWrByte | input | 8 | Byte to write |
| doneValid | output | 1 | One-cycle completion pulse of a write-channel entry |
| doneBank | output | 1 | Bank of the completed entry |
| doneIndex | output | $clog2(ENTRIES) | Index of the completed entry |
| ldByteWr | input | 1 | Host load: write one entry byte |
| ldLenWr | input | 1 | Host load: write one entry length |
| ldBank | input | 1 | Host load bank |
| ldIndex | input | $clog2(ENTRIES) | Host load entry index |
| ldOffset | input | $clog2(MAX_BYTES) | Host load byte position |
| ldByte | input | 8 | Host load byte value |
| ldLen | input | 8 | Host load length value |

## Verification
A data read's byte appears on `dataRdByte` after the rising edge that takes the strobe, so it is due one cycle after the strobe. The completion pulse is due in the cycle that follows the edge of the final write, and it lasts that one cycle only. The bench drives each access on a falling edge and holds it through a single rising edge. It samples the outputs at the next falling edge, which is exactly one cycle after the strobe. Each sample is compared with a model of the key, position, lengths and bank contents that the bench advances by the same rules.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  // Key field layout seen on the selector.
  localparam int KEY_W    = 16;
  localparam int BANK_BIT = 15;
  localparam int WCH_BIT  = 14;
  localparam int IDX_W    = 14;

  // Strobes from control to datapath.
  typedef struct packed {
    logic rdFire;   // read hits a stored byte
    logic wrFire;   // write stores a byte
    logic wrLast;   // that write completes the entry
  } strobe_t;
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int MAX_BYTES = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             selWr,
  input  logic [KEY_W-1:0] selKey,
  input  logic             dataRd,
  input  logic             dataWr,
  input  logic [LW-1:0]    curLen,
  output strobe_t          stb,
  output logic             curValid,
  output logic             curArch,
  output logic             curWch,
  output logic [IW-1:0]    curIdx,
  output logic [LW-1:0]    curOffset,
  output logic             doneValid,
  output logic             doneBank,
  output logic [IW-1:0]    doneIndex
);
  logic [IDX_W-1:0] idxField;
  logic             keyOk;
  logic             canAcc;
  logic             rdTake;
  logic             wrTake;

  assign idxField = selKey[IDX_W-1:0];
  assign keyOk    = idxField < IDX_W'(ENTRIES);
  assign canAcc   = curValid && (curOffset < curLen);
  assign rdTake   = dataRd && !selWr;
  assign wrTake   = dataWr && !dataRd && !selWr;

  always_comb begin
    stb.rdFire = rdTake && canAcc;
    stb.wrFire = wrTake && curWch && canAcc;
    stb.wrLast = stb.wrFire && ((curOffset + LW'(1)) == curLen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curValid  <= 1'b1;
      curArch   <= 1'b0;
      curWch    <= 1'b0;
      curIdx    <= '0;
      curOffset <= '0;
    end else if (selWr) begin
      curValid  <= keyOk;
      curArch   <= selKey[BANK_BIT];
      curWch    <= selKey[WCH_BIT];
      curIdx    <= idxField[IW-1:0];
      curOffset <= '0;
    end else if (stb.wrLast) begin
      curOffset <= '0;
    end else if (stb.rdFire || stb.wrFire) begin
      curOffset <= curOffset + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneValid <= 1'b0;
      doneBank  <= 1'b0;
      doneIndex <= '0;
    end else begin
      doneValid <= stb.wrLast;
      if (stb.wrLast) begin
        doneBank  <= curArch;
        doneIndex <= curIdx;
      end
    end
  end
endmodule

// File: rtl/cfgport_dp.sv
module cfgport_dp
  import cfgport_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int MAX_BYTES = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int OW = $clog2(MAX_BYTES),
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       stb,
  input  logic          curArch,
  input  logic [IW-1:0] curIdx,
  input  logic [LW-1:0] curOffset,
  input  logic          dataRd,
  input  logic [7:0]    dataWrByte,
  input  logic          ldByteWr,
  input  logic          ldLenWr,
  input  logic          ldBank,
  input  logic [IW-1:0] ldIndex,
  input  logic [OW-1:0] ldOffset,
  input  logic [7:0]    ldByte,
  input  logic [7:0]    ldLen,
  output logic [LW-1:0] curLen,
  output logic [7:0]    dataRdByte
);
  // ENTRIES and MAX_BYTES are powers of two: addresses are plain concatenations.
  localparam int AW    = 1 + IW + OW;
  localparam int DEPTH = 2 * ENTRIES * MAX_BYTES;
  localparam logic [LW-1:0] MAX_LEN = LW'(MAX_BYTES);

  logic [7:0]         mem [DEPTH];
  logic [AW-1:0]      curAddr;
  logic [AW-1:0]      ldAddr;
  logic [LW-1:0]      satLen;
  logic [1:0][LW-1:0] bankLen;

  assign curAddr = {curArch, curIdx, curOffset[OW-1:0]};
  assign ldAddr  = {ldBank, ldIndex, ldOffset};
  assign satLen  = (ldLen > 8'(MAX_BYTES)) ? MAX_LEN : LW'(ldLen);
  assign curLen  = bankLen[curArch];

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [LW-1:0] lenTab [ENTRIES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int e = 0; e < ENTRIES; e++) lenTab[e] <= '0;
        end else if (ldLenWr && (ldBank == 1'(b))) begin
          lenTab[ldIndex] <= satLen;
        end
      end
      assign bankLen[b] = lenTab[curIdx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ldByteWr) mem[ldAddr] <= ldByte;
    else if (stb.wrFire) mem[curAddr] <= dataWrByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dataRdByte <= 8'h00;
    else if (dataRd) dataRdByte <= stb.rdFire ? mem[curAddr] : 8'h00;
  end
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfgport_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int MAX_BYTES = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int OW = $clog2(MAX_BYTES),
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          selWr,
  input  logic [15:0]   selKey,
  input  logic          dataRd,
  output logic [7:0]    dataRdByte,
  input  logic          dataWr,
  input  logic [7:0]    dataWrByte,
  output logic          doneValid,
  output logic          doneBank,
  output logic [IW-1:0] doneIndex,
  input  logic          ldByteWr,
  input  logic          ldLenWr,
  input  logic          ldBank,
  input  logic [IW-1:0] ldIndex,
  input  logic [OW-1:0] ldOffset,
  input  logic [7:0]    ldByte,
  input  logic [7:0]    ldLen
);
  strobe_t       stb;
  logic          curValid;
  logic          curArch;
  logic          curWch;
  logic [IW-1:0] curIdx;
  logic [LW-1:0] curOffset;
  logic [LW-1:0] curLen;

  cfgport_ctrl #(.ENTRIES(ENTRIES), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .selWr(selWr), .selKey(selKey),
    .dataRd(dataRd), .dataWr(dataWr), .curLen(curLen), .stb(stb),
    .curValid(curValid), .curArch(curArch), .curWch(curWch),
    .curIdx(curIdx), .curOffset(curOffset), .doneValid(doneValid),
    .doneBank(doneBank), .doneIndex(doneIndex)
  );

  cfgport_dp #(.ENTRIES(ENTRIES), .MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .curArch(curArch),
    .curIdx(curIdx), .curOffset(curOffset), .dataRd(dataRd),
    .dataWrByte(dataWrByte), .ldByteWr(ldByteWr), .ldLenWr(ldLenWr),
    .ldBank(ldBank), .ldIndex(ldIndex), .ldOffset(ldOffset),
    .ldByte(ldByte), .ldLen(ldLen), .curLen(curLen),
    .dataRdByte(dataRdByte)
  );
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int MAX_BYTES = 16,
  localparam int LW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          selWr,
  input logic          dataRd,
  input logic          dataWr,
  input logic          ldByteWr,
  input logic          ldLenWr,
  input logic          doneValid,
  input logic [7:0]    dataRdByte,
  input logic          curValid,
  input logic          curWch,
  input logic [LW-1:0] curOffset,
  input logic [LW-1:0] curLen
);
  p_sel_clears_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    selWr |=> curOffset == '0);

  p_invalid_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRd && !selWr && !curValid) |=> (dataRdByte == 8'h00) && (curOffset == $past(curOffset)));

  p_past_end_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRd && !selWr && curValid && (curOffset >= curLen))
      |=> (dataRdByte == 8'h00) && (curOffset == $past(curOffset)));

  p_ro_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dataWr && !dataRd && !selWr && !curWch) |=> (curOffset == $past(curOffset)) && !doneValid);

  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> $past(dataWr) && (curOffset == '0));

  p_host_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ldByteWr || ldLenWr) |-> !dataRd && !dataWr);

  p_read_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRd && dataWr) |=> !doneValid);
endmodule

bind cfg_keyport cfgport_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .selWr(selWr), .dataRd(dataRd), .dataWr(dataWr),
  .ldByteWr(ldByteWr), .ldLenWr(ldLenWr), .doneValid(doneValid),
  .dataRdByte(dataRdByte), .curValid(curValid), .curWch(curWch),
  .curOffset(curOffset), .curLen(curLen)
);

// File: tb/cfg_keyport_tb.sv
module cfg_keyport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 8;
  localparam int MAX_BYTES  = 16;
  localparam int IW = $clog2(ENTRIES);
  localparam int OW = $clog2(MAX_BYTES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          selWr = 1'b0;
  logic [15:0]   selKey = '0;
  logic          dataRd = 1'b0;
  logic [7:0]    dataRdByte;
  logic          dataWr = 1'b0;
  logic [7:0]    dataWrByte = '0;
  logic          doneValid;
  logic          doneBank;
  logic [IW-1:0] doneIndex;
  logic          ldByteWr = 1'b0;
  logic          ldLenWr = 1'b0;
  logic          ldBank = 1'b0;
  logic [IW-1:0] ldIndex = '0;
  logic [OW-1:0] ldOffset = '0;
  logic [7:0]    ldByte = '0;
  logic [7:0]    ldLen = '0;

  int nChecks = 0;
  int nFails  = 0;

  // Reference model state.
  logic [7:0] mMem [2][ENTRIES][MAX_BYTES];
  int  mLen [2][ENTRIES];
  bit  mValid, mArch, mWch;
  int  mIdx, mOff;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_keyport #(.ENTRIES(ENTRIES), .MAX_BYTES(MAX_BYTES)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadLen(input bit b, input int idx, input int len);
    ldLenWr = 1'b1; ldBank = b; ldIndex = IW'(idx); ldLen = 8'(len);
    tick();
    ldLenWr = 1'b0;
    mLen[b][idx] = (len > MAX_BYTES) ? MAX_BYTES : len;
  endtask

  task automatic loadByte(input bit b, input int idx, input int off, input logic [7:0] v);
    ldByteWr = 1'b1; ldBank = b; ldIndex = IW'(idx); ldOffset = OW'(off); ldByte = v;
    tick();
    ldByteWr = 1'b0;
    mMem[b][idx][off] = v;
  endtask

  // One access cycle: any mix of select, read and write, modelled and checked.
  task automatic step(input bit s, input logic [15:0] key, input bit r, input bit w,
                      input logic [7:0] wb, input string req);
    logic [7:0] expByte = 8'h00;
    bit expDone = 1'b0;
    bit expBank = 1'b0;
    int expIdx = 0;
    selWr = s; selKey = key; dataRd = r; dataWr = w; dataWrByte = wb;
    if (s) begin
      mValid = (int'(key[13:0]) < ENTRIES);
      mArch = key[15]; mWch = key[14]; mIdx = int'(key[13:0]) % ENTRIES; mOff = 0;
    end else if (r) begin
      if (mValid && mOff < mLen[mArch][mIdx]) begin
        expByte = mMem[mArch][mIdx][mOff];
        mOff++;
      end
    end else if (w) begin
      if (mValid && mWch && mOff < mLen[mArch][mIdx]) begin
        mMem[mArch][mIdx][mOff] = wb;
        mOff++;
        if (mOff == mLen[mArch][mIdx]) begin
          expDone = 1'b1; expBank = mArch; expIdx = mIdx; mOff = 0;
        end
      end
    end
    tick();
    selWr = 1'b0; dataRd = 1'b0; dataWr = 1'b0;
    if (r) check(dataRdByte === expByte, req, dataRdByte, expByte);
    check(doneValid === expDone, {req, " done"}, doneValid, expDone);
    if (expDone) begin
      check(doneBank === expBank, "R6 bank", doneBank, expBank);
      check(int'(doneIndex) == expIdx, "R6 index", doneIndex, expIdx);
    end
  endtask

  task automatic sel(input logic [15:0] key);
    step(1'b1, key, 1'b0, 1'b0, 8'h00, "R1");
  endtask
  task automatic rd(input string req);
    step(1'b0, 16'h0, 1'b1, 1'b0, 8'h00, req);
  endtask
  task automatic wr(input logic [7:0] v, input string req);
    step(1'b0, 16'h0, 1'b0, 1'b1, v, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < ENTRIES; e++) begin
        mLen[b][e] = 0;
        for (int o = 0; o < MAX_BYTES; o++) mMem[b][e][o] = 8'h00;
      end
    mValid = 1'b1; mArch = 1'b0; mWch = 1'b0; mIdx = 0; mOff = 0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(dataRdByte === 8'h00, "R7 rd byte", dataRdByte, 0);
    check(doneValid === 1'b0, "R7 done", doneValid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Zero bytes in storage so the model agrees with the banks.
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < ENTRIES; e++)
        for (int o = 0; o < MAX_BYTES; o++) loadByte(b[0], e, o, 8'h00);
    rd("R7 empty key0");
    // R7: signature at key 0 readable without any select after reset.
    loadByte(1'b0, 0, 0, 8'h43); loadByte(1'b0, 0, 1, 8'h46);
    loadByte(1'b0, 0, 2, 8'h47); loadByte(1'b0, 0, 3, 8'h4B);
    loadLen(1'b0, 0, 4);
    for (int i = 0; i < 4; i++) rd("R7 signature");
    rd("R3 past end");
    rd("R3 past end again");
    // R4: same index in both banks.
    for (int i = 0; i < 4; i++) begin
      loadByte(1'b0, 3, i, 8'(8'h10 + i));
      loadByte(1'b1, 3, i, 8'(8'hA0 + i));
    end
    loadLen(1'b0, 3, 4); loadLen(1'b1, 3, 2);
    sel(16'h0003); rd("R4 bank0"); rd("R4 bank0");
    sel(16'h8003); rd("R4 bank1"); rd("R4 bank1"); rd("R4 bank1 end");
    // R1: reselect rewinds.
    sel(16'h0003); rd("R1 rewind");
    step(1'b1, 16'h0003, 1'b1, 1'b0, 8'h00, "R1 sel+rd zero");
    rd("R1 after sel+rd");
    // R2: invalid keys.
    sel(16'h0008); rd("R2 invalid"); rd("R2 invalid");
    sel(16'h7FFF); rd("R2 invalid");
    sel(16'h4008); wr(8'h55, "R2 write"); rd("R2 invalid read");
    // R5, R6: write channel at bank 1 entry 5, length 3.
    loadLen(1'b1, 5, 3);
    sel(16'hC005);
    wr(8'h11, "R5 write"); wr(8'h22, "R5 write"); wr(8'h33, "R6 last write");
    wr(8'h44, "R6 wrap write");
    sel(16'h8005); rd("R5 readback"); rd("R5 readback"); rd("R5 readback");
    // R5: write through read-only key changes nothing.
    sel(16'h0003); wr(8'hEE, "R5 ro write");
    sel(16'h0003); rd("R5 ro check");
    // R9: read and write together.
    sel(16'hC005);
    step(1'b0, 16'h0, 1'b1, 1'b1, 8'h99, "R9 rd+wr");
    rd("R9 next byte");
    // R8: length saturation.
    loadLen(1'b0, 6, 200);
    for (int i = 0; i < MAX_BYTES; i++) loadByte(1'b0, 6, i, 8'(i * 7 + 1));
    sel(16'h0006);
    for (int i = 0; i <= MAX_BYTES; i++) rd("R8 saturated length");
    // Random mix.
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [15:0] key;
      op = int'($urandom_range(0, 9));
      key = {1'($urandom), 1'($urandom), 14'($urandom_range(0, ENTRIES + 1))};
      if (op == 0) begin
        int b = int'($urandom_range(0, 1));
        int e = int'($urandom_range(0, ENTRIES - 1));
        loadLen(b[0], e, int'($urandom_range(0, MAX_BYTES + 2)));
      end else if (op < 3) sel(key);
      else if (op < 6) rd("R3 random");
      else if (op < 9) wr(8'($urandom), "R5 random");
      else step(1'b0, 16'h0, 1'b1, 1'b1, 8'($urandom), "R9 random");
    end
    finishRun();
  end
endmodule